// File: doc/BRIEF.md
# Asynchronous ROM Read Controller

This block is a clocked host-side sequencer for an external asynchronous 16-bit ROM. The ROM has an active-low chip select and an active-low output strobe. A requester hands over an 18-bit word address on a valid/ready handshake. The controller then drives the address and pulls chip select low. Output enable follows later, timed so that the output-enable access window ends together with the address access window. On the clock edge that ends that window the controller captures the ROM data bus and returns the word with a single-cycle response strobe.

After the capture, both strobes rise together and the controller waits out a float-recovery interval. During that interval the ROM may still be driving the data bus, so no new access may start. Chip select stays high whenever no access is in flight, which keeps the device in low-power standby. Only one read can be outstanding at a time.

The three waits are parameters counted in clock cycles: address access, output-enable access and float recovery. The address access wait must be larger than the output-enable wait.

Top module: `romReadCtrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, romCeN and romOeN are 1, reqReady is 1 and rspValid is 0.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. A reqValid raised while reqReady is 0 changes neither romAddr nor the strobes, and it produces no response.
- R3: romCeN is 0 for exactly ADDR_WAIT cycles. Those cycles start in the cycle after the accepting edge. For all of them romAddr equals the accepted address and does not change.
- R4: romOeN is 0 for exactly the last OE_WAIT cycles of the chip-select window. romOeN is never 0 while romCeN is 1.
- R5: rspData is the value on romData at the clock edge that ends the chip-select window. rspValid is 1 for exactly the one cycle after that edge.
- R6: Outside the chip-select window, which includes idle and float recovery, romCeN and romOeN are both 1.
- R7: reqReady is 0 for ADDR_WAIT+FLOAT_WAIT cycles after the accepting edge, then returns to 1. Back-to-back requests are therefore accepted ADDR_WAIT+FLOAT_WAIT+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 18 | Word address of the request |
| reqReady | output | 1 | Controller can take a request |
| rspValid | output | 1 | One-cycle strobe marking returned data |
| rspData | output | 16 | Returned ROM word |
| romAddr | output | 18 | Address driven to the ROM |
| romCeN | output | 1 | ROM chip select, active low |
| romOeN | output | 1 | ROM output enable, active low |
| romData | input | 16 | ROM data bus |

## Verification
The bench's ROM model returns a decoy value unless both strobes have been low for their full access windows. A read that captures too early therefore returns the wrong word, which separates correct capture timing from an off-by-one. Three address patterns are used: a dense sweep of low addresses, a walking one across all 18 bits plus all ones, and address pairs issued back to back. The dense sweep checks the data path. The walking one exposes a stuck or swapped address bit. The back-to-back pairs check the minimum acceptance spacing and show that recovery is not skipped. A request raised while the controller is busy and then withdrawn shows that busy requests are ignored.

// File: rtl/romReadPkg.sv
package romReadPkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LEAD    = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } phase_t;

  typedef struct packed {
    logic loadAddr;
    logic captureData;
  } dpStrobe_t;
endpackage

// File: rtl/romReadFsm.sv
module romReadFsm
  import romReadPkg::*;
#(
  parameter int ADDR_WAIT  = 4,
  parameter int OE_WAIT    = 2,
  parameter int FLOAT_WAIT = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      romCeN,
  output logic      romOeN,
  output dpStrobe_t strobe
);
  localparam int LEAD_CYC = ADDR_WAIT - OE_WAIT;
  localparam int MAX_A    = (LEAD_CYC > OE_WAIT) ? LEAD_CYC : OE_WAIT;
  localparam int MAX_C    = (MAX_A > FLOAT_WAIT) ? MAX_A : FLOAT_WAIT;
  localparam int CNT_W    = $clog2(MAX_C + 1);

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    strobe    = '0;
    unique case (phase)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadAddr = 1'b1;
          phaseNext       = ST_LEAD;
          cntNext         = CNT_W'(LEAD_CYC - 1);
        end
      end
      ST_LEAD: begin
        if (cntDone) begin
          phaseNext = ST_STROBE;
          cntNext   = CNT_W'(OE_WAIT - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cntDone) begin
          strobe.captureData = 1'b1;
          phaseNext          = ST_RECOVER;
          cntNext            = CNT_W'(FLOAT_WAIT - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cntDone) phaseNext = ST_IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
    end
  end

  assign reqReady = (phase == ST_IDLE);
  assign romCeN   = !((phase == ST_LEAD) || (phase == ST_STROBE));
  assign romOeN   = (phase != ST_STROBE);

  // R4: output enable only inside the chip-select window
  assert_oe_inside_ce_R4: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN);

  // R7: after a capture the controller is still busy for the recovery interval
  assert_busy_after_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureData |=> !reqReady);
endmodule

// File: rtl/romReadDatapath.sv
module romReadDatapath
  import romReadPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] romData,
  input  logic              romCeN,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr  <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (strobe.loadAddr)    romAddr <= reqAddr;
      if (strobe.captureData) rspData <= romData;
      rspValid <= strobe.captureData;
    end
  end

  // R3: address held steady through the chip-select window
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && !strobe.loadAddr) |=> (romCeN || $stable(romAddr)));

  // R5: response strobe lasts exactly one cycle
  assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/romReadCtrl.sv
module romReadCtrl
  import romReadPkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int ADDR_WAIT  = 4,
  parameter int OE_WAIT    = 2,
  parameter int FLOAT_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  input  logic [DATA_W-1:0] romData
);
  dpStrobe_t strobe;

  romReadFsm #(
    .ADDR_WAIT (ADDR_WAIT),
    .OE_WAIT   (OE_WAIT),
    .FLOAT_WAIT(FLOAT_WAIT)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .romCeN  (romCeN),
    .romOeN  (romOeN),
    .strobe  (strobe)
  );

  romReadDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .romData (romData),
    .romCeN  (romCeN),
    .romAddr (romAddr),
    .rspData (rspData),
    .rspValid(rspValid)
  );

  // R6: response is delivered with the device already in standby
  assert_standby_on_rsp_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (romCeN && romOeN));

  // R5: the end of the output-enable window coincides with the response
  assert_oe_end_rsp_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romOeN) |-> rspValid);
endmodule

// File: tb/romReadCtrl_test.sv
module romReadCtrl_test;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int A  = 4;
  localparam int O  = 2;
  localparam int F  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic reqReady, rspValid, romCeN, romOeN;
  logic [DW-1:0] rspData, romData;
  logic [AW-1:0] romAddr;

  int checks = 0;
  int fails = 0;
  int ceCnt = 0;
  int oeCnt = 0;

  always #2.5 clk = ~clk;

  romReadCtrl #(.ADDR_W(AW), .DATA_W(DW), .ADDR_WAIT(A), .OE_WAIT(O), .FLOAT_WAIT(F)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN), .romData(romData));

  function automatic logic [DW-1:0] romWord(input logic [AW-1:0] a);
    romWord = (a[15:0] * 16'd3) ^ {14'h0, a[17:16]} ^ 16'hA55A;
  endfunction

  // ROM model: valid data only after both access windows are met
  always_ff @(posedge clk) begin
    ceCnt <= romCeN ? 0 : ceCnt + 1;
    oeCnt <= romOeN ? 0 : oeCnt + 1;
  end
  assign romData = (!romCeN && !romOeN && ceCnt + 1 >= A && oeCnt + 1 >= O)
                   ? romWord(romAddr) : (16'hDEAD ^ romAddr[15:0]);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // issue one read; returns at the negedge where reqReady is back
  task automatic doRead(input logic [AW-1:0] a, input bit poke);
    int ceLow = 0, oeLow = 0, rspAt = 0, rdyLow = 0;
    bit addrOk = 1, stbyOk = 1, orderOk = 1;
    logic [DW-1:0] got = '0;
    reqValid = 1'b1;
    reqAddr  = a;
    check(reqReady == 1'b1, "R2", "ready before accept", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = ~a;
    for (int i = 1; i <= A + F + 1; i++) begin
      if (i > 1) @(negedge clk);
      if (poke && i == 2) reqValid = 1'b1;
      if (poke && i == A + F) reqValid = 1'b0;
      if (!romCeN) ceLow++;
      if (!romOeN) oeLow++;
      if (!romOeN && romCeN) orderOk = 0;
      if (i <= A && romAddr != a) addrOk = 0;
      if (i <= A && romCeN) stbyOk = 0;
      if (i > A && (!romCeN || !romOeN)) stbyOk = 0;
      if (i > A - O && i <= A && romOeN) orderOk = 0;
      if (!reqReady) rdyLow++;
      if (i <= A + F && reqReady) rdyLow = -100;
      if (rspValid) begin
        if (rspAt != 0) rspAt = -1; else rspAt = i;
        got = rspData;
      end
    end
    check(ceLow == A, "R3", "ce low cycles", ceLow, A);
    check(addrOk, "R3", "address held", romAddr, a);
    check(oeLow == O && orderOk, "R4", "oe low cycles/placement", oeLow, O);
    check(rspAt == A + 1, "R5", "response cycle", rspAt, A + 1);
    check(got == romWord(a), "R5", "response data", got, romWord(a));
    check(stbyOk, "R6", "standby outside window", romCeN, 1);
    check(rdyLow == A + F && reqReady, "R7", "ready low cycles", rdyLow, A + F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(romCeN && romOeN, "R1", "strobes in reset", {romCeN, romOeN}, 3);
    check(reqReady && !rspValid, "R1", "ready/rsp in reset", {reqReady, rspValid}, 2);
    rstN = 1'b1;
    @(negedge clk);
    check(romCeN && romOeN && reqReady && !rspValid, "R1", "after reset",
          {romCeN, romOeN, reqReady, rspValid}, 4'b1110);
    // dense low-address sweep with an idle gap
    for (int k = 0; k < 64; k++) begin
      doRead(AW'(k), 0);
      @(negedge clk);
    end
    // walking one and all ones
    for (int b = 0; b < AW; b++) begin
      doRead(AW'(1) << b, 0);
      @(negedge clk);
    end
    doRead({AW{1'b1}}, 0);
    // back-to-back pairs: next request offered the moment ready returns
    for (int k = 0; k < 16; k++) begin
      doRead(AW'(k * 4099 + 7), 0);
      doRead(AW'(k * 8191 + 3), 0);
    end
    // R2: request raised while busy, withdrawn before ready returns
    doRead(AW'(18'h2AAAA), 1);
    for (int i = 0; i < 4; i++) begin
      check(romCeN && !rspValid, "R2", "busy request ignored", {romCeN, rspValid}, 2);
      check(romAddr == AW'(18'h2AAAA), "R2", "address unchanged", romAddr, 18'h2AAAA);
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule